// File: doc/BRIEF.md
# Byte Replication Transmit Rate Adapter

This block sits between a GMII-style byte source running at 10, 100 or 1000 Mb/s and an 8B/10B PCS that always consumes one byte per 125 MHz cycle. The source presents a byte with its enable and error flags and pulses a strobe when that byte is new. A two-bit speed select sets how many output cycles each accepted byte occupies. The count is 1 at gigabit, 10 at 100 Mb/s and 100 at 10 Mb/s. A frame is therefore stretched in time, and the start delimiter still occurs only once in it.

The adapter locks the speed while a frame is in progress. It also watches the start of every frame and raises a one-cycle fault pulse when the preamble is too short for the PCS or does not end in the delimiter byte. When no new byte arrives after the replication count runs out, the output falls back to an idle all-zero byte.

Top module: `gmii_byte_stretcher`

## Requirements
- R1: A byte accepted with `in_stb` high appears on `out_data` in the cycle after the accepting clock edge. The output presents exactly one byte on every clock cycle.
- R2: With speed code 2'b01 (100 Mb/s), an accepted byte is held on the output for exactly 10 consecutive cycles.
- R3: With speed code 2'b00 (10 Mb/s), an accepted byte is held on the output for exactly 100 consecutive cycles.
- R4: With speed code 2'b10 (1000 Mb/s), and also with the unused code 2'b11, each accepted byte occupies exactly one output cycle, so consecutive strobes pass through one-for-one.
- R5: `out_dv` and `out_er` carry the `in_en` and `in_err` values captured with the byte. They are repeated over the same cycles as that byte.
- R6: A frame runs from a strobe with `in_en`=1 until a strobe with `in_en`=0. While a frame is open, the replication count follows the speed code in force at the frame's first byte, and changes on `speed_sel` have no effect. Outside a frame, the live `speed_sel` value applies to the next strobe.
- R7: When the replication count of the last byte has run out and no strobe arrives, the outputs are idle: `out_dv`=0, `out_er`=0 and `out_data`=8'h00.
- R8: `preamble_fault` pulses for one cycle, aligned with the first output cycle of the first byte in a frame that is not 8'h55, in two cases. The first case is that fewer than two 8'h55 bytes came before that byte. The second case is that the byte is not the delimiter 8'hD5. A frame that opens with at least two 8'h55 bytes followed by 8'hD5 raises no pulse.
- R9: A strobe that arrives before the current byte's replication has run out replaces the byte at once and restarts the count for the new byte.
- R10: After reset the outputs are zero, `preamble_fault` is low and no frame is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz output-side clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_stb | input | 1 | High for one cycle when a new input byte is presented |
| in_data | input | 8 | Input byte |
| in_en | input | 1 | Input byte belongs to a frame |
| in_err | input | 1 | Input byte carries an error mark |
| speed_sel | input | 2 | 00 = 10 Mb/s, 01 = 100 Mb/s, 10 = 1000 Mb/s, 11 = treated as 1000 |
| out_data | output | 8 | Output byte, one per clock |
| out_dv | output | 1 | Replicated enable flag |
| out_er | output | 1 | Replicated error flag |
| preamble_fault | output | 1 | One-cycle pulse on a malformed frame start |

## Verification
The bench runs frames at every speed code, with preamble runs of zero to three bytes. It also sends one frame whose first non-preamble byte is not the delimiter. A checker that counted the preamble one byte off, or that ignored the delimiter value, would raise the fault for a good frame or miss it for a bad one.

Inside one frame the bench changes the speed select. A design without the lock would switch to 100-fold replication mid-frame. The bench then checks that the next frame takes the new speed.

Two further cases target counter bugs. An early strobe checks that the count restarts instead of finishing the old byte. Exact idle checks after each final byte catch off-by-one replication counts, which would show one cycle too many or too few.

// File: rtl/rate_adapt_pkg.sv
package rate_adapt_pkg;

    typedef enum logic [1:0] {
        SPD_10   = 2'b00,
        SPD_100  = 2'b01,
        SPD_1000 = 2'b10,
        SPD_RSVD = 2'b11
    } speed_e;

    typedef struct packed {
        logic [7:0] data;
        logic       en;
        logic       er;
    } gbyte_t;

    localparam logic [7:0] PRE_BYTE = 8'h55;
    localparam logic [7:0] SFD_BYTE = 8'hD5;

    localparam gbyte_t IDLE_BYTE = '{data: 8'h00, en: 1'b0, er: 1'b0};

endpackage

// File: rtl/rate_speed_lock.sv
module rate_speed_lock
    import rate_adapt_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   stb,
    input  logic   en,
    input  speed_e speed_in,
    output speed_e speed_eff,
    output speed_e speed_lock,
    output logic   frame_open
);

    typedef struct packed {
        speed_e spd;
        logic   frame;
    } lock_st_t;

    lock_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // Outside a frame the live select is tracked every cycle.
        if (!st_q.frame) begin
            st_d.spd = speed_in;
        end
        if (stb) begin
            st_d.frame = en;
        end
        speed_eff = st_q.frame ? st_q.spd : speed_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{spd: SPD_1000, frame: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign speed_lock = st_q.spd;
    assign frame_open = st_q.frame;

endmodule

// File: rtl/rate_byte_stretch.sv
module rate_byte_stretch
    import rate_adapt_pkg::*;
#(
    parameter int REP_FAST = 10,
    parameter int REP_SLOW = 100,
    localparam int CNT_W   = $clog2(REP_SLOW)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stb,
    input  gbyte_t           byte_in,
    input  speed_e           speed_eff,
    output gbyte_t           byte_out,
    output logic [CNT_W-1:0] rep_left
);

    localparam logic [CNT_W-1:0] LOAD_SLOW = CNT_W'(REP_SLOW - 1);
    localparam logic [CNT_W-1:0] LOAD_FAST = CNT_W'(REP_FAST - 1);
    localparam logic [CNT_W-1:0] LOAD_ONE  = '0;

    typedef struct packed {
        gbyte_t           hold;
        logic [CNT_W-1:0] cnt;
    } str_st_t;

    str_st_t st_d, st_q;
    logic [CNT_W-1:0] load_val;

    always_comb begin
        unique case (speed_eff)
            SPD_10:  load_val = LOAD_SLOW;
            SPD_100: load_val = LOAD_FAST;
            default: load_val = LOAD_ONE;
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (stb) begin
            st_d.hold = byte_in;
            st_d.cnt  = load_val;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end else begin
            st_d.hold = IDLE_BYTE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{hold: IDLE_BYTE, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign byte_out = st_q.hold;
    assign rep_left = st_q.cnt;

endmodule

// File: rtl/rate_preamble_check.sv
module rate_preamble_check
    import rate_adapt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stb,
    input  logic [7:0] data,
    input  logic       en,
    input  logic       frame_open,
    output logic       fault
);

    typedef struct packed {
        logic       hunting;
        logic [1:0] run;
        logic       fault;
    } pre_st_t;

    pre_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.fault = 1'b0;
        if (stb && !en) begin
            st_d.hunting = 1'b0;
            st_d.run     = '0;
        end else if (stb && !frame_open) begin
            // First byte of a new frame.
            if (data == PRE_BYTE) begin
                st_d.hunting = 1'b1;
                st_d.run     = 2'd1;
            end else begin
                st_d.hunting = 1'b0;
                st_d.run     = '0;
                st_d.fault   = 1'b1;
            end
        end else if (stb && st_q.hunting) begin
            if (data == PRE_BYTE) begin
                st_d.run = (st_q.run == 2'd2) ? 2'd2 : st_q.run + 2'd1;
            end else begin
                st_d.hunting = 1'b0;
                st_d.fault   = (st_q.run < 2'd2) || (data != SFD_BYTE);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{hunting: 1'b0, run: 2'd0, fault: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign fault = st_q.fault;

endmodule

// File: rtl/gmii_byte_stretcher.sv
module gmii_byte_stretcher
    import rate_adapt_pkg::*;
#(
    parameter int REP_FAST = 10,
    parameter int REP_SLOW = 100,
    localparam int CNT_W   = $clog2(REP_SLOW)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_stb,
    input  logic [7:0] in_data,
    input  logic       in_en,
    input  logic       in_err,
    input  logic [1:0] speed_sel,
    output logic [7:0] out_data,
    output logic       out_dv,
    output logic       out_er,
    output logic       preamble_fault
);

    speed_e           spd_eff;
    speed_e           spd_lock;
    logic             frame_act;
    logic [CNT_W-1:0] rep_left;
    gbyte_t           byte_in;
    gbyte_t           byte_out;

    assign byte_in = '{data: in_data, en: in_en, er: in_err};

    rate_speed_lock u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .stb        (in_stb),
        .en         (in_en),
        .speed_in   (speed_e'(speed_sel)),
        .speed_eff  (spd_eff),
        .speed_lock (spd_lock),
        .frame_open (frame_act)
    );

    rate_byte_stretch #(
        .REP_FAST (REP_FAST),
        .REP_SLOW (REP_SLOW)
    ) u_str (
        .clk       (clk),
        .rst_n     (rst_n),
        .stb       (in_stb),
        .byte_in   (byte_in),
        .speed_eff (spd_eff),
        .byte_out  (byte_out),
        .rep_left  (rep_left)
    );

    rate_preamble_check u_pre (
        .clk        (clk),
        .rst_n      (rst_n),
        .stb        (in_stb),
        .data       (in_data),
        .en         (in_en),
        .frame_open (frame_act),
        .fault      (preamble_fault)
    );

    assign out_data = byte_out.data;
    assign out_dv   = byte_out.en;
    assign out_er   = byte_out.er;

endmodule

// File: rtl/gmii_byte_stretcher_chk.sv
module gmii_byte_stretcher_chk #(
    parameter int REP_FAST = 10,
    parameter int CNT_W    = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_stb,
    input logic [7:0]       in_data,
    input logic             in_en,
    input logic             in_err,
    input logic [1:0]       speed_sel,
    input logic [7:0]       out_data,
    input logic             out_dv,
    input logic             out_er,
    input logic             preamble_fault,
    input logic [CNT_W-1:0] rep_left,
    input logic             frame_q,
    input logic [1:0]       spd_q
);

    AST_LOAD_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        in_stb |=> out_data == $past(in_data) && out_dv == $past(in_en) && out_er == $past(in_err)); // R5

    AST_HOLD_REP: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_stb && rep_left != '0) |=> $stable(out_data) && $stable(out_dv) && $stable(out_er)); // R2

    AST_IDLE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_stb && rep_left == '0) |=> !out_dv && !out_er && out_data == 8'h00); // R7

    AST_SPEED_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_stb && frame_q && spd_q == 2'b01) |=> rep_left == CNT_W'(REP_FAST - 1)); // R6

    AST_GIGA_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_stb && !frame_q && speed_sel[1]) |=> rep_left == '0); // R4

    AST_FAULT_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        preamble_fault |-> out_dv && $past(in_stb)); // R8

endmodule

bind gmii_byte_stretcher gmii_byte_stretcher_chk #(
    .REP_FAST (REP_FAST),
    .CNT_W    (CNT_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_stb         (in_stb),
    .in_data        (in_data),
    .in_en          (in_en),
    .in_err         (in_err),
    .speed_sel      (speed_sel),
    .out_data       (out_data),
    .out_dv         (out_dv),
    .out_er         (out_er),
    .preamble_fault (preamble_fault),
    .rep_left       (rep_left),
    .frame_q        (frame_act),
    .spd_q          (spd_lock)
);

// File: tb/gmii_byte_stretcher_tb_top.sv
module gmii_byte_stretcher_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_stb = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_en = 1'b0;
    logic       in_err = 1'b0;
    logic [1:0] speed_sel = 2'b10;
    logic [7:0] out_data;
    logic       out_dv;
    logic       out_er;
    logic       preamble_fault;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    gmii_byte_stretcher dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .in_stb         (in_stb),
        .in_data        (in_data),
        .in_en          (in_en),
        .in_err         (in_err),
        .speed_sel      (speed_sel),
        .out_data       (out_data),
        .out_dv         (out_dv),
        .out_er         (out_er),
        .preamble_fault (preamble_fault)
    );

    function automatic int reps(input logic [1:0] s);
        return (s == 2'b00) ? 100 : (s == 2'b01) ? 10 : 1;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Called at a negedge; returns at the negedge of the last replica.
    task automatic send(input logic [7:0] d, input bit en, input bit er,
                        input int n, input bit expf, input string req);
        in_data = d; in_en = en; in_err = er; in_stb = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_stb = 1'b0;
        for (int i = 0; i < n; i++) begin
            if (i > 0) @(negedge clk);
            chk(out_data == d, req, out_data, d);
            chk(out_dv == en && out_er == er, "R5", {out_dv, out_er}, {en, er});
            chk(preamble_fault == ((i == 0) ? expf : 1'b0), "R8", preamble_fault, (i == 0) ? expf : 1'b0);
        end
    endtask

    task automatic idle_chk(input int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            chk(!out_dv && !out_er && out_data == 8'h00, "R7", {out_data, out_dv, out_er}, 0);
        end
    endtask

    function automatic string req_of(input logic [1:0] s);
        return (s == 2'b00) ? "R3" : (s == 2'b01) ? "R2" : "R4";
    endfunction

    task automatic frame(input logic [1:0] s, input int npre, input logic [7:0] delim, input bit bad_delim);
        int n = reps(s);
        speed_sel = s;
        for (int p = 0; p < npre; p++) send(8'h55, 1'b1, 1'b0, n, 1'b0, req_of(s));
        send(delim, 1'b1, 1'b0, n, (npre < 2) || bad_delim, "R8");
        for (int k = 0; k < 3; k++) send(8'(s * 16 + k + 1), 1'b1, (k == 1), n, 1'b0, "R1");
        send(8'h00, 1'b0, 1'b0, n, 1'b0, req_of(s));
        idle_chk(2);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(out_data == 8'h00 && !out_dv && !out_er, "R10", {out_data, out_dv, out_er}, 0);
        chk(preamble_fault == 1'b0, "R10", preamble_fault, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Sweep speed codes and preamble lengths (R2, R3, R4, R8).
        for (int s = 0; s < 4; s++) begin
            for (int npre = 0; npre < 4; npre++) begin
                frame(2'(s), npre, 8'hD5, 1'b0);
            end
        end
        // Wrong delimiter after a full preamble (R8).
        frame(2'b01, 2, 8'h12, 1'b1);

        // Speed lock inside a frame (R6).
        speed_sel = 2'b01;
        send(8'h55, 1'b1, 1'b0, 10, 1'b0, "R6");
        send(8'h55, 1'b1, 1'b0, 10, 1'b0, "R6");
        speed_sel = 2'b00;
        send(8'hD5, 1'b1, 1'b0, 10, 1'b0, "R6");
        send(8'hA7, 1'b1, 1'b0, 10, 1'b0, "R6");
        send(8'h00, 1'b0, 1'b0, 10, 1'b0, "R6");
        idle_chk(1);
        send(8'h3C, 1'b0, 1'b0, 100, 1'b0, "R6");
        idle_chk(2);

        // Early strobe replaces the held byte (R9).
        speed_sel = 2'b01;
        in_data = 8'hAA; in_en = 1'b0; in_err = 1'b0; in_stb = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_stb = 1'b0;
        chk(out_data == 8'hAA, "R9", out_data, 8'hAA);
        @(negedge clk);
        chk(out_data == 8'hAA, "R9", out_data, 8'hAA);
        send(8'hBB, 1'b0, 1'b1, 10, 1'b0, "R9");
        idle_chk(2);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule